// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block fills a hardware-managed translation cache on a miss. A requester hands it a 20-bit virtual page number and the byte address of the root table. The walker splits the page number into an upper 10-bit root index and a lower 10-bit leaf index. It reads the root entry through a single read port with a request/acknowledge handshake. If that entry is valid, it reads the leaf entry from the table the root entry points to. It then returns the leaf entry, or a fault that says which level was invalid. The table format is fixed by the hardware and no software takes part in the walk.

Only one walk is active at a time. The walker raises `busy` for the whole walk. It ends the walk with a one-cycle `walk_done` or `walk_fault` pulse, and `busy` is low in that same cycle. A requester that holds `walk_req` high can therefore start the next walk at once.

Top module: `ptw_walker`

## Requirements
- R1: After a synchronous reset, `busy`, `walk_done`, `walk_fault` and `mem_req` are all low.
- R2: When `walk_req` is high and `busy` is low at a clock edge, the walk is accepted. From the next cycle `busy` and `mem_req` are high, and `mem_addr` equals `root_base + 4 * walk_vpn[19:10]`.
- R3: While `mem_req` is high and no acknowledge has arrived, `mem_addr` and `mem_req` stay unchanged, for any number of wait cycles.
- R4: A valid root entry leads to a second read at `{entry[31:12], 12'h000} + 4 * walk_vpn[9:0]`.
- R5: The valid flag of an entry is bit 0 (1 = valid). An invalid root entry ends the walk with `walk_fault` and `fault_lvl` = 0, after exactly one memory read.
- R6: An invalid leaf entry ends the walk with `walk_fault` and `fault_lvl` = 1, after exactly two memory reads.
- R7: A valid leaf entry ends the walk with a one-cycle `walk_done` pulse, and `walk_pte` equals the leaf entry. `walk_done` and `walk_fault` are never high together.
- R8: `busy` is low in the cycle where a result pulse is high. A `walk_req` seen while `busy` is high is ignored and starts no walk.
- R9: A request presented in the cycle of a result pulse is accepted at the next edge.
- R10: On a fault, `walk_pte` carries the invalid entry that caused it.
- R11: `root_base` and `walk_vpn` are sampled only when a walk is accepted. Changing them during a walk does not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_req | input | 1 | Walk request |
| walk_vpn | input | 20 | Virtual page number to translate |
| root_base | input | 32 | Byte address of the root table |
| busy | output | 1 | High while a walk is in progress |
| walk_done | output | 1 | One-cycle pulse: translation found |
| walk_fault | output | 1 | One-cycle pulse: invalid entry found |
| fault_lvl | output | 1 | Level of the fault: 0 root, 1 leaf |
| walk_pte | output | 32 | Final leaf entry, or the faulting entry |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read byte address |
| mem_ack | input | 1 | Read acknowledge; data is valid with it |
| mem_rdata | input | 32 | Read data |

## Verification
Two events can share a cycle: the result pulse of one walk and the acceptance of the next, because `busy` drops as the pulse rises. The bench provokes this by issuing each new walk at the first falling edge where `busy` is low, which is the result cycle itself. It then checks that the root read of the new walk appears on the next cycle. A scoreboard compares every result pulse with the outcome computed from the table model. It also checks the number of reads counted since the last result, so a skipped or extra read shows up even when the returned entry looks right.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROOT = 2'd1,
    ST_LEAF = 2'd2
  } walk_st_t;

  // Bit 0 of every table entry marks it valid.
  function automatic logic entry_ok(input logic [31:0] e);
    return e[0];
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int ENT_B  = 4
) (
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] ent_addr
);
  localparam int SHIFT = $clog2(ENT_B);
  localparam int PADW  = ADDR_W - IDX_W - SHIFT;

  always_comb begin
    ent_addr = tbl_base + {{PADW{1'b0}}, idx, {SHIFT{1'b0}}};
  end
endmodule

// File: rtl/ptw_mem_port.sv
module ptw_mem_port #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else if (issue) begin
      mem_req  <= 1'b1;
      mem_addr <= issue_addr;
    end else if (mem_ack) begin
      mem_req  <= 1'b0;
    end
  end

  assign rd_valid = mem_req && mem_ack;

  p_hold_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  parameter int VPN_W  = 20,
  parameter int ROOT_W = 10,
  parameter int PG_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              walk_req,
  input  logic [VPN_W-1:0]  walk_vpn,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              rd_valid,
  input  logic [PTE_W-1:0]  rd_data,
  output logic              issue,
  output logic [ADDR_W-1:0] issue_addr,
  output logic              busy,
  output logic              walk_done,
  output logic              walk_fault,
  output logic              fault_lvl,
  output logic [PTE_W-1:0]  walk_pte
);
  localparam int LEAF_W = VPN_W - ROOT_W;
  localparam int ENT_B  = PTE_W / 8;

  walk_st_t             st;
  logic [LEAF_W-1:0]    leaf_idx;
  logic [ADDR_W-1:0]    root_ent_addr;
  logic [ADDR_W-1:0]    leaf_ent_addr;
  logic [ADDR_W-1:0]    leaf_tbl;
  logic                 accept;

  assign accept   = walk_req && (st == ST_IDLE);
  assign leaf_tbl = {rd_data[PTE_W-1:PG_W], {PG_W{1'b0}}};

  ptw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(ROOT_W), .ENT_B(ENT_B)) u_root_ag (
    .tbl_base (root_base),
    .idx      (walk_vpn[VPN_W-1:LEAF_W]),
    .ent_addr (root_ent_addr)
  );

  ptw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(LEAF_W), .ENT_B(ENT_B)) u_leaf_ag (
    .tbl_base (leaf_tbl),
    .idx      (leaf_idx),
    .ent_addr (leaf_ent_addr)
  );

  always_comb begin
    issue      = 1'b0;
    issue_addr = root_ent_addr;
    if (accept) begin
      issue = 1'b1;
    end else if (st == ST_ROOT && rd_valid && entry_ok(rd_data)) begin
      issue      = 1'b1;
      issue_addr = leaf_ent_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      leaf_idx   <= '0;
      busy       <= 1'b0;
      walk_done  <= 1'b0;
      walk_fault <= 1'b0;
      fault_lvl  <= 1'b0;
      walk_pte   <= '0;
    end else begin
      walk_done  <= 1'b0;
      walk_fault <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st       <= ST_ROOT;
            leaf_idx <= walk_vpn[LEAF_W-1:0];
            busy     <= 1'b1;
          end
        end
        ST_ROOT: begin
          if (rd_valid) begin
            if (entry_ok(rd_data)) begin
              st <= ST_LEAF;
            end else begin
              st         <= ST_IDLE;
              busy       <= 1'b0;
              walk_fault <= 1'b1;
              fault_lvl  <= 1'b0;
              walk_pte   <= rd_data;
            end
          end
        end
        ST_LEAF: begin
          if (rd_valid) begin
            st         <= ST_IDLE;
            busy       <= 1'b0;
            walk_pte   <= rd_data;
            fault_lvl  <= 1'b1;
            walk_done  <= entry_ok(rd_data);
            walk_fault <= !entry_ok(rd_data);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !busy) |=> busy);
  p_one_result_r7: assert property (@(posedge clk) disable iff (rst)
    !(walk_done && walk_fault));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> !walk_done);
  p_free_on_result_r8: assert property (@(posedge clk) disable iff (rst)
    (walk_done || walk_fault) |-> !busy);
  p_fault_has_invalid_r10: assert property (@(posedge clk) disable iff (rst)
    walk_fault |-> !walk_pte[0]);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  parameter int VPN_W  = 20,
  parameter int ROOT_W = 10,
  parameter int PG_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              walk_req,
  input  logic [VPN_W-1:0]  walk_vpn,
  input  logic [ADDR_W-1:0] root_base,
  output logic              busy,
  output logic              walk_done,
  output logic              walk_fault,
  output logic              fault_lvl,
  output logic [PTE_W-1:0]  walk_pte,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [PTE_W-1:0]  mem_rdata
);
  logic              issue;
  logic [ADDR_W-1:0] issue_addr;
  logic              rd_valid;

  ptw_mem_port #(.ADDR_W(ADDR_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_addr (issue_addr),
    .mem_ack    (mem_ack),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .rd_valid   (rd_valid)
  );

  ptw_fsm #(
    .ADDR_W(ADDR_W), .PTE_W(PTE_W), .VPN_W(VPN_W),
    .ROOT_W(ROOT_W), .PG_W(PG_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .walk_req   (walk_req),
    .walk_vpn   (walk_vpn),
    .root_base  (root_base),
    .rd_valid   (rd_valid),
    .rd_data    (mem_rdata),
    .issue      (issue),
    .issue_addr (issue_addr),
    .busy       (busy),
    .walk_done  (walk_done),
    .walk_fault (walk_fault),
    .fault_lvl  (fault_lvl),
    .walk_pte   (walk_pte)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        walk_req = 1'b0;
  logic [19:0] walk_vpn = '0;
  logic [31:0] root_base = '0;
  logic        busy, walk_done, walk_fault, fault_lvl, mem_req;
  logic [31:0] walk_pte, mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst(rst), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .root_base(root_base), .busy(busy), .walk_done(walk_done),
    .walk_fault(walk_fault), .fault_lvl(fault_lvl), .walk_pte(walk_pte),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int failures = 0;
  int reads = 0;
  int reads_mark = 0;
  int slow = 0;
  int b2b_seen = 0;
  bit finished = 0;

  typedef struct {
    logic        flt;
    logic        lvl;
    logic [31:0] pte;
    int          nrd;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    logic [31:0] v;
    v = a * 32'h9E3779B1;
    v = v ^ (v >> 15);
    v = v * 32'h85EBCA6B;
    v = v ^ (v >> 13);
    return {v[31:1], v[1] | v[2]};
  endfunction

  function automatic exp_t model(input logic [19:0] vpn, input logic [31:0] base);
    exp_t e;
    logic [31:0] m, s;
    m = memf(base + {20'd0, vpn[19:10], 2'b00});
    if (!m[0]) begin
      e.flt = 1'b1; e.lvl = 1'b0; e.pte = m; e.nrd = 1;
    end else begin
      s = memf({m[31:12], 12'h000} + {20'd0, vpn[9:0], 2'b00});
      e.flt = !s[0]; e.lvl = 1'b1; e.pte = s; e.nrd = 2;
    end
    return e;
  endfunction

  // Memory model with variable wait states; R3 stability check.
  bit          pend = 0;
  logic [31:0] held;
  int          wcnt = 0;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      pend = 0;
    end else if (mem_req) begin
      if (!pend) begin
        pend = 1;
        held = mem_addr;
        wcnt = slow ? 4 + (reads % 4) : (reads * 7) % 3;
      end
      if (wcnt == 0) begin
        chk(mem_addr == held, "R3", "addr held until ack", mem_addr, held);
        mem_ack = 1'b1;
        mem_rdata = memf(mem_addr);
        reads++;
      end else begin
        wcnt--;
      end
    end
  end

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst && (walk_done || walk_fault)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8", "unexpected result", {31'd0, walk_done}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(walk_fault == e.flt, e.flt ? (e.lvl ? "R6" : "R5") : "R7",
            "fault flag", {31'd0, walk_fault}, {31'd0, e.flt});
        chk(walk_done == !e.flt, "R7", "done flag", {31'd0, walk_done}, {31'd0, !e.flt});
        chk(walk_pte == e.pte, e.flt ? "R10" : "R4", "entry", walk_pte, e.pte);
        if (e.flt)
          chk(fault_lvl == e.lvl, e.lvl ? "R6" : "R5", "fault level",
              {31'd0, fault_lvl}, {31'd0, e.lvl});
        chk(reads - reads_mark == e.nrd, e.nrd == 1 ? "R5" : "R6", "read count",
            reads - reads_mark, e.nrd);
        chk(!busy, "R8", "busy low with result", {31'd0, busy}, 32'd0);
        reads_mark = reads;
      end
    end
  end

  task automatic issue(input logic [19:0] vpn, input logic [31:0] base, input bit disturb);
    bit was_result;
    @(negedge clk);
    while (busy) @(negedge clk);
    was_result = walk_done || walk_fault;
    walk_req = 1'b1;
    walk_vpn = vpn;
    root_base = base;
    sb.push_back(model(vpn, base));
    @(negedge clk);
    chk(busy && mem_req, was_result ? "R9" : "R2", "accepted", {30'd0, busy, mem_req}, 32'd3);
    chk(mem_addr == base + {20'd0, vpn[19:10], 2'b00}, "R2", "root address",
        mem_addr, base + {20'd0, vpn[19:10], 2'b00});
    if (was_result) b2b_seen++;
    if (disturb) begin
      walk_vpn = ~vpn;
      root_base = base ^ 32'hFFF0_0000;
      @(negedge clk);
    end
    walk_req = 1'b0;
  endtask

  function automatic logic [19:0] find(input int kind, input logic [31:0] base);
    for (int j = 1; j < 4096; j++) begin
      exp_t e;
      logic [19:0] v;
      v = 20'(j * 2654435 + 12345);
      e = model(v, base);
      if (kind == 0 && e.flt && !e.lvl) return v;
      if (kind == 1 && e.flt && e.lvl) return v;
      if (kind == 2 && !e.flt) return v;
    end
    return 20'h00001;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", sb.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [19:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !walk_done && !walk_fault && !mem_req, "R1", "reset state",
        {28'd0, busy, walk_done, walk_fault, mem_req}, 32'd0);
    rst = 1'b0;

    issue(find(0, 32'h0010_0000), 32'h0010_0000, 0);  // R5 root fault
    issue(find(1, 32'h0010_0000), 32'h0010_0000, 0);  // R6 leaf fault
    issue(find(2, 32'h0010_0000), 32'h0010_0000, 0);  // R7 translation
    // R11 / R8: inputs change and request held during the walk
    issue(find(2, 32'h0020_0000), 32'h0020_0000, 1);
    issue(find(0, 32'h0020_0000), 32'h0020_0000, 1);
    // R3: long wait states
    slow = 1;
    issue(find(2, 32'h0030_0000), 32'h0030_0000, 0);
    issue(find(1, 32'h0030_0000), 32'h0030_0000, 0);
    slow = 0;
    // R9: back-to-back walks over mixed patterns
    lf = 20'hACE1;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[18:0], lf[19] ^ lf[16]};
      issue(lf, 32'h0040_0000 + 32'(k[3:0]) * 32'h0001_1000, 0);
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(b2b_seen > 0, "R9", "back-to-back acceptance seen", b2b_seen, 1);
    chk(!busy && !mem_req, "R1", "idle at end", {30'd0, busy, mem_req}, 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule